// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that moves 32-bit words between memory regions and peripherals. Software does not program the source, destination and length directly. It places a descriptor in memory, writes the descriptor's address into the channel and sets the run bit. The channel reads the descriptor through its own memory master port and performs the copy one word at a time. Each side can step its address by four bytes after every word or keep it fixed. Either side can be ignored, and either side can be held back by a peripheral request line.

When a descriptor finishes, the channel reads its link word. A non-zero link makes the channel load and run the next descriptor without going idle. A zero link stops the channel and sets the done flag. An interrupt is raised only for descriptors that ask for one.

Software can stop the channel part-way through a chain. A memory error response also halts it and is latched in a separate error register. A self-clearing channel reset returns the channel to its power-up state.

Top module: `dma_chan_top`

## Requirements
- R1: After reset, the status register (word 0) reads 0, `irq` is low, `memReq` is low and every other register reads 0.
- R2: Writing the descriptor-address register (word 1) keeps only bits 31..6, so descriptors sit on 64-byte boundaries. A write to it while the channel is running or resetting has no effect.
- R3: Writing status bit 0 as 1 while idle starts the channel. It reads six words at descriptor+0, +4, +8, +12, +16 and +20 into the read-only registers control (word 2), source (3), destination (4), byte length (5), stride (6) and link (7).
- R4: A descriptor moves length/4 words. Each word is one read at the source address followed by one write at the destination address. Control bit 8 makes the source step by 4 after each word and control bit 4 does the same for the destination; when a bit is clear, that side's address stays fixed.
- R5: Control bit 11 set means no source reads, and zero is written for each word. Control bit 7 set means no destination writes.
- R6: With a zero link, the end of the descriptor clears status bit 0 (running) and sets status bit 1 (done). Status bit 2 and `irq` are set only when control bit 0 of the finished descriptor is 1. A length below 4 moves no data.
- R7: Writing 1 to status bit 1 or bit 2 clears that flag, and `irq` follows bit 2.
- R8: With a non-zero link, the channel loads the link (aligned down to 64 bytes) as the new descriptor address and runs that descriptor while still running. Each descriptor's interrupt bit applies to its own completion.
- R9: Control bit 10 holds every source read, and control bit 6 holds every destination write, until `periphReq[sel]` is high, where sel is control bits 20..16 (values at or above the port width read as low). While held, status bit 5 reads 1. Status bit 3 shows the selected request level.
- R10: Writing status bit 30 while running makes the channel stop at the next word boundary. Running clears, done stays clear, and no further memory access is made. Bit 30 reads 1 until the channel stops.
- R11: An error response on the memory port stops the channel without setting done. It sets bit 0 of the error register (word 8) for a source read, bit 1 for a destination write, and bit 2 for a descriptor read. Status bit 8 is the OR of those bits, and writing ones to the error register clears them.
- R12: Writing status bit 31 resets the channel at once. It clears all registers and flags, and bit 31 reads 1 for RST_CYCLES cycles, then clears itself.
- R13: Once `memReq` is raised, it stays high with a stable `memAddr` until `memAck` or `memErr` is seen, unless a channel reset is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 4 | Register word index (byte offset / 4) |
| regWe | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regSel`, combinational |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Request is a write |
| memAddr | output | AW | Byte address of the word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with `memAck` |
| memAck | input | 1 | Request completed |
| memErr | input | 1 | Request failed |
| periphReq | input | NUM_PERIPH | Peripheral request lines |
| irq | output | 1 | Interrupt, mirrors status bit 2 |

## Verification
The copy engine is run over a table of descriptors that combine source and destination stepping, fixed addresses, ignored sides, interrupt enable and several lengths. A reference loop in the bench predicts every destination word and the first word past the end. This separates a fixed source (all words equal) from a fixed destination (only the last value survives) from an ignored side (zeros, or untouched memory). Directed runs then cover a two-descriptor chain with the interrupt only on the second, a stalled transfer on each pacing side, abort during a stall, a source-read error, zero length, alignment and write protection of the descriptor address, and the self-clearing channel reset.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  // status register bit positions
  localparam int CS_ACTIVE  = 0;
  localparam int CS_END     = 1;
  localparam int CS_INT     = 2;
  localparam int CS_REQLVL  = 3;
  localparam int CS_WAITREQ = 5;
  localparam int CS_ERROR   = 8;
  localparam int CS_ABORT   = 30;
  localparam int CS_RESET   = 31;

  // descriptor control word bit positions
  localparam int TI_INTEN   = 0;
  localparam int TI_DINC    = 4;
  localparam int TI_DPACE   = 6;
  localparam int TI_DIGN    = 7;
  localparam int TI_SINC    = 8;
  localparam int TI_SPACE   = 10;
  localparam int TI_SIGN    = 11;
  localparam int TI_MAP_LSB = 16;
  localparam int TI_MAP_W   = 5;

  localparam int CB_FIELDS     = 6;   // words read from a descriptor
  localparam int CB_ALIGN_BITS = 6;   // 64-byte descriptor alignment

  // register word indices
  localparam logic [3:0] RI_CS     = 4'd0;
  localparam logic [3:0] RI_CB     = 4'd1;
  localparam logic [3:0] RI_TI     = 4'd2;
  localparam logic [3:0] RI_SRC    = 4'd3;
  localparam logic [3:0] RI_DST    = 4'd4;
  localparam logic [3:0] RI_LEN    = 4'd5;
  localparam logic [3:0] RI_STRIDE = 4'd6;
  localparam logic [3:0] RI_NEXT   = 4'd7;
  localparam logic [3:0] RI_DBG    = 4'd8;

  typedef enum logic [1:0] {SEL_CB, SEL_SRC, SEL_DST} memSel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_SETUP, S_RPACE, S_READ, S_WPACE, S_WRITE, S_BEND, S_RST
  } chanState_e;

  // decoded control-word fields used by the sequencer
  typedef struct packed {
    logic                srcIgn;
    logic                srcPace;
    logic                dstIgn;
    logic                dstPace;
    logic                intEn;
    logic [TI_MAP_W-1:0] perMap;
  } tiCtl_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    memSel_e    memSel;
    logic       fetchClr;
    logic       fetchInc;
    logic       loadCb;
    logic       capture;
    logic       captureZero;
    logic       advance;
    logic       loadNext;
    logic       clear;
    logic [2:0] setErr;
  } dpStrobe_t;

endpackage

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     ctl,
  input  logic [31:0]   memRdata,
  input  logic          cbWe,
  input  logic [AW-1:CB_ALIGN_BITS] cbWrData,
  input  logic          dbgWe,
  input  logic [2:0]    dbgClr,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  output tiCtl_t        tiCtl,
  output logic [31:0]   tiReg,
  output logic [AW-1:0] cbAddr,
  output logic [AW-1:0] srcAddr,
  output logic [AW-1:0] dstAddr,
  output logic [31:0]   lenBytes,
  output logic [31:0]   strideReg,
  output logic [AW-1:0] nextCb,
  output logic [2:0]    dbgErr,
  output logic          fetchLast,
  output logic          lenDone,
  output logic          nextZero
);

  localparam int FIW = $clog2(CB_FIELDS);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [FIW-1:0] fetchIdx;
  logic [31:0]    dataBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchIdx <= '0;
      dataBuf  <= '0;
      tiReg    <= '0;
      cbAddr   <= '0;
      srcAddr  <= '0;
      dstAddr  <= '0;
      lenBytes <= '0;
      strideReg <= '0;
      nextCb   <= '0;
      dbgErr   <= '0;
    end else if (ctl.clear) begin
      fetchIdx <= '0;
      dataBuf  <= '0;
      tiReg    <= '0;
      cbAddr   <= '0;
      srcAddr  <= '0;
      dstAddr  <= '0;
      lenBytes <= '0;
      strideReg <= '0;
      nextCb   <= '0;
      dbgErr   <= '0;
    end else begin
      if (ctl.fetchClr)      fetchIdx <= '0;
      else if (ctl.fetchInc) fetchIdx <= fetchIdx + 1'b1;

      if (ctl.loadCb) begin
        unique case (fetchIdx)
          FIW'(0): tiReg     <= memRdata;
          FIW'(1): srcAddr   <= AW'(memRdata);
          FIW'(2): dstAddr   <= AW'(memRdata);
          FIW'(3): lenBytes  <= memRdata;
          FIW'(4): strideReg <= memRdata;
          default: nextCb    <= AW'(memRdata);
        endcase
      end

      if (ctl.capture)          dataBuf <= memRdata;
      else if (ctl.captureZero) dataBuf <= '0;

      if (ctl.advance) begin
        if (tiReg[TI_SINC]) srcAddr <= srcAddr + STEP;
        if (tiReg[TI_DINC]) dstAddr <= dstAddr + STEP;
        lenBytes <= lenBytes - 32'd4;
      end

      if (ctl.loadNext)
        cbAddr <= {nextCb[AW-1:CB_ALIGN_BITS], {CB_ALIGN_BITS{1'b0}}};
      else if (cbWe)
        cbAddr <= {cbWrData, {CB_ALIGN_BITS{1'b0}}};

      dbgErr <= (dbgErr & ~(dbgWe ? dbgClr : 3'b000)) | ctl.setErr;
    end
  end

  always_comb begin
    unique case (ctl.memSel)
      SEL_SRC: memAddr = srcAddr;
      SEL_DST: memAddr = dstAddr;
      default: memAddr = cbAddr + AW'({fetchIdx, 2'b00});
    endcase
  end

  assign memWdata  = dataBuf;
  assign fetchLast = (fetchIdx == FIW'(CB_FIELDS - 1));
  assign lenDone   = (lenBytes[31:2] == '0);
  assign nextZero  = (nextCb == '0);

  assign tiCtl.srcIgn  = tiReg[TI_SIGN];
  assign tiCtl.srcPace = tiReg[TI_SPACE];
  assign tiCtl.dstIgn  = tiReg[TI_DIGN];
  assign tiCtl.dstPace = tiReg[TI_DPACE];
  assign tiCtl.intEn   = tiReg[TI_INTEN];
  assign tiCtl.perMap  = tiReg[TI_MAP_LSB +: TI_MAP_W];

  // R4: every step moves the length down by exactly one word
  p_len_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.clear) |=> (lenBytes == $past(lenBytes) - 32'd4));

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csWe,
  input  logic [31:0] csWrData,
  input  tiCtl_t      ti,
  input  logic        reqLevel,
  input  logic        fetchLast,
  input  logic        lenDone,
  input  logic        nextZero,
  input  logic        memAck,
  input  logic        memErr,
  output dpStrobe_t   ctl,
  output logic        memReq,
  output logic        memWe,
  output logic        active,
  output logic        endFlag,
  output logic        intFlag,
  output logic        abortReq,
  output logic        waiting,
  output logic        rstBusy
);

  localparam int RCW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

  chanState_e state, stateNext;
  logic [RCW-1:0] rstCnt;
  logic setInt, setEnd;

  wire rstCmd   = csWe && csWrData[CS_RESET];
  wire startCmd = csWe && csWrData[CS_ACTIVE] && !csWrData[CS_RESET] && (state == S_IDLE);
  wire abortCmd = csWe && csWrData[CS_ABORT] && active;

  always_comb begin
    ctl       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    stateNext = state;
    setInt    = 1'b0;
    setEnd    = 1'b0;
    waiting   = 1'b0;
    unique case (state)
      S_IDLE: if (startCmd) begin
        ctl.fetchClr = 1'b1;
        stateNext    = S_FETCH;
      end
      S_FETCH: begin
        memReq     = 1'b1;
        ctl.memSel = SEL_CB;
        if (memErr) begin
          ctl.setErr = 3'b100;
          stateNext  = S_IDLE;
        end else if (memAck) begin
          ctl.loadCb = 1'b1;
          if (fetchLast) stateNext = S_SETUP;
          else           ctl.fetchInc = 1'b1;
        end
      end
      S_SETUP: begin
        if (abortReq)     stateNext = S_IDLE;
        else if (lenDone) stateNext = S_BEND;
        else              stateNext = S_RPACE;
      end
      S_RPACE: begin
        if (abortReq) stateNext = S_IDLE;
        else if (ti.srcPace && !reqLevel) waiting = 1'b1;
        else if (ti.srcIgn) begin
          ctl.captureZero = 1'b1;
          stateNext       = S_WPACE;
        end else stateNext = S_READ;
      end
      S_READ: begin
        memReq     = 1'b1;
        ctl.memSel = SEL_SRC;
        if (memErr) begin
          ctl.setErr = 3'b001;
          stateNext  = S_IDLE;
        end else if (memAck) begin
          ctl.capture = 1'b1;
          stateNext   = S_WPACE;
        end
      end
      S_WPACE: begin
        if (abortReq) stateNext = S_IDLE;
        else if (ti.dstPace && !reqLevel) waiting = 1'b1;
        else if (ti.dstIgn) begin
          ctl.advance = 1'b1;
          stateNext   = S_SETUP;
        end else stateNext = S_WRITE;
      end
      S_WRITE: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        ctl.memSel = SEL_DST;
        if (memErr) begin
          ctl.setErr = 3'b010;
          stateNext  = S_IDLE;
        end else if (memAck) begin
          ctl.advance = 1'b1;
          stateNext   = S_SETUP;
        end
      end
      S_BEND: begin
        setInt = ti.intEn;
        if (nextZero) begin
          setEnd    = 1'b1;
          stateNext = S_IDLE;
        end else begin
          ctl.loadNext = 1'b1;
          ctl.fetchClr = 1'b1;
          stateNext    = S_FETCH;
        end
      end
      S_RST: if (rstCnt == '0) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
    if (rstCmd) begin
      ctl.clear = 1'b1;
      stateNext = S_RST;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      rstCnt   <= '0;
      endFlag  <= 1'b0;
      intFlag  <= 1'b0;
      abortReq <= 1'b0;
    end else begin
      state <= stateNext;
      if (rstCmd)                          rstCnt <= RCW'(RST_CYCLES - 1);
      else if (state == S_RST && rstCnt != '0) rstCnt <= rstCnt - 1'b1;

      if (rstCmd)                        endFlag <= 1'b0;
      else if (setEnd)                   endFlag <= 1'b1;
      else if (csWe && csWrData[CS_END]) endFlag <= 1'b0;

      if (rstCmd)                        intFlag <= 1'b0;
      else if (setInt)                   intFlag <= 1'b1;
      else if (csWe && csWrData[CS_INT]) intFlag <= 1'b0;

      if (rstCmd || stateNext == S_IDLE) abortReq <= 1'b0;
      else if (abortCmd)                 abortReq <= 1'b1;
    end
  end

  assign active  = (state != S_IDLE) && (state != S_RST);
  assign rstBusy = (state == S_RST);

  // R12: a reset write is visible as busy on the next cycle, with the channel stopped
  p_reset_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    rstCmd |=> (rstBusy && !active));

  // R6: done only ever rises together with the channel stopping
  p_end_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endFlag) |-> !active);

  // R6: the interrupt flag rises only for a descriptor that enables it
  p_int_enabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> $past(ti.intEn));

  // R9: a held source read stays held while the request line is low
  p_pace_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RPACE && ti.srcPace && !reqLevel && !abortReq && !csWe) |=> (state == S_RPACE));

  // R11: an error response stops the channel on the next cycle
  p_err_stop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memErr) |=> !active);

  // R10: a pending abort never survives into idle
  p_abort_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !abortReq);

endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
  import dma_chan_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NUM_PERIPH = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [3:0]            regSel,
  input  logic                  regWe,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  output logic                  memReq,
  output logic                  memWe,
  output logic [AW-1:0]         memAddr,
  output logic [31:0]           memWdata,
  input  logic [31:0]           memRdata,
  input  logic                  memAck,
  input  logic                  memErr,
  input  logic [NUM_PERIPH-1:0] periphReq,
  output logic                  irq
);

  dpStrobe_t     ctl;
  tiCtl_t        tiCtl;
  logic [31:0]   tiReg, lenBytes, strideReg;
  logic [AW-1:0] cbAddr, srcAddr, dstAddr, nextCb;
  logic [2:0]    dbgErr;
  logic fetchLast, lenDone, nextZero;
  logic active, endFlag, intFlag, abortReq, waiting, rstBusy;
  logic reqLevel;

  wire csWe  = regWe && (regSel == RI_CS);
  wire cbWe  = regWe && (regSel == RI_CB) && !active && !rstBusy;
  wire dbgWe = regWe && (regSel == RI_DBG);

  wire unusedWrBits = ^{regWrData[29:CS_ERROR], regWrData[7:3]};

  always_comb begin
    reqLevel = 1'b0;
    for (int i = 0; i < NUM_PERIPH; i++)
      if (tiCtl.perMap == TI_MAP_W'(i)) reqLevel = periphReq[i];
  end

  dma_chan_ctrl #(.RST_CYCLES(RST_CYCLES)) i_ctrl (
    .clk, .rstN,
    .csWe, .csWrData(regWrData),
    .ti(tiCtl), .reqLevel, .fetchLast, .lenDone, .nextZero,
    .memAck, .memErr,
    .ctl, .memReq, .memWe,
    .active, .endFlag, .intFlag, .abortReq, .waiting, .rstBusy
  );

  dma_chan_dp #(.AW(AW)) i_dp (
    .clk, .rstN, .ctl, .memRdata,
    .cbWe, .cbWrData(regWrData[AW-1:CB_ALIGN_BITS]),
    .dbgWe, .dbgClr(regWrData[2:0]),
    .memAddr, .memWdata, .tiCtl, .tiReg,
    .cbAddr, .srcAddr, .dstAddr, .lenBytes, .strideReg, .nextCb,
    .dbgErr, .fetchLast, .lenDone, .nextZero
  );

  always_comb begin
    regRdData = '0;
    unique case (regSel)
      RI_CS: begin
        regRdData[CS_RESET]   = rstBusy;
        regRdData[CS_ABORT]   = abortReq;
        regRdData[CS_ERROR]   = |dbgErr;
        regRdData[CS_WAITREQ] = waiting;
        regRdData[CS_REQLVL]  = reqLevel;
        regRdData[CS_INT]     = intFlag;
        regRdData[CS_END]     = endFlag;
        regRdData[CS_ACTIVE]  = active;
      end
      RI_CB:     regRdData = 32'(cbAddr);
      RI_TI:     regRdData = tiReg;
      RI_SRC:    regRdData = 32'(srcAddr);
      RI_DST:    regRdData = 32'(dstAddr);
      RI_LEN:    regRdData = lenBytes;
      RI_STRIDE: regRdData = strideReg;
      RI_NEXT:   regRdData = 32'(nextCb);
      RI_DBG:    regRdData = {29'b0, dbgErr};
      default:   regRdData = '0;
    endcase
  end

  assign irq = intFlag;

  // R13: an unanswered request keeps its address until answered
  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memErr && !(csWe && regWrData[CS_RESET]))
      |=> (memReq && $stable(memAddr)));

  // R2: the descriptor address cannot change while the channel runs, except by chaining
  p_cb_locked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (active && !ctl.loadNext && !(csWe && regWrData[CS_RESET])) |=> $stable(cbAddr));

endmodule

// File: tb/test_dma_chan_top.sv
module test_dma_chan_top;

  localparam int AW = 32;
  localparam int NP = 4;
  localparam int RC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] regSel = '0;
  logic regWe = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic memAck = 1'b0;
  logic memErr = 1'b0;
  logic [NP-1:0] periphReq = '0;
  logic irq;

  logic [31:0] mem [0:255];
  logic [31:0] errAddr = 32'hFFFF_FFFF;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_chan_top #(.AW(AW), .NUM_PERIPH(NP), .RST_CYCLES(RC)) i_dma_chan_top (
    .clk, .rstN, .regSel, .regWe, .regWrData, .regRdData,
    .memReq, .memWe, .memAddr, .memWdata, .memRdata, .memAck, .memErr,
    .periphReq, .irq
  );

  // memory model: one-cycle answer to each request
  always @(posedge clk) begin
    memAck <= 1'b0;
    memErr <= 1'b0;
    if (rstN && memReq && !memAck && !memErr) begin
      if (memAddr == errAddr) memErr <= 1'b1;
      else begin
        memAck   <= 1'b1;
        memRdata <= mem[memAddr[9:2]];
        if (memWe) mem[memAddr[9:2]] <= memWdata;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regWrData = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [3:0] sel, output logic [31:0] d);
    @(negedge clk);
    regSel = sel;
    #1 d = regRdData;
  endtask

  task automatic putCb(input int base, input logic [31:0] ti, input logic [31:0] src,
                       input logic [31:0] dst, input logic [31:0] len, input logic [31:0] nxt);
    mem[base/4 + 0] = ti;
    mem[base/4 + 1] = src;
    mem[base/4 + 2] = dst;
    mem[base/4 + 3] = len;
    mem[base/4 + 4] = 32'h55;
    mem[base/4 + 5] = nxt;
  endtask

  task automatic fillData();
    for (int i = 0; i < 16; i++) begin
      mem[64 + i]  = 32'hC0DE_0000 + 32'(i * 17 + 3);
      mem[128 + i] = 32'hDEAD_BEEF;
    end
  endtask

  task automatic startAt(input logic [31:0] cb);
    regWrite(4'd1, cb);
    regWrite(4'd0, 32'h1);
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int n = 0; n < 3000; n++) begin
      regRead(4'd0, v);
      if (!v[0]) break;
    end
  endtask

  task automatic idleFor(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [31:0] mkTi(input bit sInc, input bit dInc, input bit sIgn,
                                       input bit dIgn, input bit ie);
    return (32'(sInc) << 8) | (32'(dInc) << 4) | (32'(sIgn) << 11) | (32'(dIgn) << 7) | 32'(ie);
  endfunction

  // {srcInc, dstInc, srcIgn, dstIgn, intEn, words[3:0]}
  localparam logic [8:0] VEC [6] = '{
    {5'b11001, 4'd4},
    {5'b10000, 4'd3},
    {5'b01001, 4'd3},
    {5'b01101, 4'd2},
    {5'b11010, 4'd2},
    {5'b11001, 4'd1}
  };

  initial begin
    logic [31:0] v, ti, d;
    logic [31:0] exp [16];
    for (int i = 0; i < 256; i++) mem[i] = '0;

    // R1: reset state
    #1;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 memReq", 32'(memReq), 0);
    idleFor(3);
    rstN = 1'b1;
    regRead(4'd0, v); chk("R1 status", v, 0);
    regRead(4'd1, v); chk("R1 cbaddr", v, 0);
    regRead(4'd2, v); chk("R1 ctrl", v, 0);
    regRead(4'd8, v); chk("R1 errreg", v, 0);

    // R2: alignment of the descriptor address
    regWrite(4'd1, 32'h0000_0047);
    regRead(4'd1, v); chk("R2 align", v, 32'h40);

    // table walk: R4 R5 R6 R7 R3
    for (int t = 0; t < 6; t++) begin
      bit sInc, dInc, sIgn, dIgn, ie;
      int n;
      {sInc, dInc, sIgn, dIgn, ie} = VEC[t][8:4];
      n = int'(VEC[t][3:0]);
      fillData();
      ti = mkTi(sInc, dInc, sIgn, dIgn, ie);
      putCb(0, ti, 32'h100, 32'h200, 32'(n * 4), 0);
      for (int j = 0; j < 16; j++) exp[j] = 32'hDEAD_BEEF;
      for (int k = 0; k < n; k++) begin
        d = sIgn ? 32'h0 : mem[64 + (sInc ? k : 0)];
        if (!dIgn) exp[dInc ? k : 0] = d;
      end
      startAt(32'h0);
      waitIdle();
      for (int j = 0; j <= n; j++)
        chk($sformatf("R4/R5 vec%0d word%0d", t, j), mem[128 + j], exp[j]);
      regRead(4'd0, v); chk($sformatf("R6 vec%0d status", t), v, ie ? 32'h6 : 32'h2);
      chk($sformatf("R6 vec%0d irq", t), 32'(irq), 32'(ie));
      if (t == 0) begin
        regRead(4'd2, v); chk("R3 ctrl readback", v, ti);
        regRead(4'd6, v); chk("R3 stride readback", v, 32'h55);
        regRead(4'd5, v); chk("R3 length after", v, 0);
        regRead(4'd3, v); chk("R4 src after", v, 32'h110);
      end
      regWrite(4'd0, 32'h6);
      regRead(4'd0, v); chk($sformatf("R7 vec%0d cleared", t), v, 0);
      chk($sformatf("R7 vec%0d irq low", t), 32'(irq), 0);
    end

    // R7: clearing only done keeps the interrupt flag
    fillData();
    putCb(0, mkTi(1, 1, 0, 0, 1), 32'h100, 32'h200, 4, 0);
    startAt(32'h0); waitIdle();
    regWrite(4'd0, 32'h2);
    regRead(4'd0, v); chk("R7 partial clear", v, 32'h4);
    regWrite(4'd0, 32'h4);

    // R6: zero length moves nothing
    fillData();
    putCb(0, mkTi(1, 1, 0, 0, 1), 32'h100, 32'h200, 3, 0);
    startAt(32'h0); waitIdle();
    chk("R6 zero len dst", mem[128], 32'hDEAD_BEEF);
    regRead(4'd0, v); chk("R6 zero len status", v, 32'h6);
    regWrite(4'd0, 32'h6);

    // R8: two-descriptor chain, interrupt only on the second
    fillData();
    putCb(0,  mkTi(1, 1, 0, 0, 0), 32'h100, 32'h200, 8, 32'h4A);
    putCb(64, mkTi(1, 1, 0, 0, 1), 32'h110, 32'h210, 4, 0);
    startAt(32'h0); waitIdle();
    chk("R8 chain w0", mem[128], mem[64]);
    chk("R8 chain w1", mem[129], mem[65]);
    chk("R8 chain gap", mem[130], 32'hDEAD_BEEF);
    chk("R8 chain w4", mem[132], mem[68]);
    regRead(4'd1, v); chk("R8 cbaddr aligned link", v, 32'h40);
    regRead(4'd0, v); chk("R8 status", v, 32'h6);
    regWrite(4'd0, 32'h6);

    // R9: source pacing, plus R2 write protection while running
    fillData();
    putCb(0, mkTi(1, 1, 0, 0, 1) | (32'h1 << 10) | (32'd2 << 16), 32'h100, 32'h200, 8, 0);
    startAt(32'h0);
    idleFor(30);
    regRead(4'd0, v); chk("R9 stalled status", v, 32'h21);
    chk("R9 no write yet", mem[128], 32'hDEAD_BEEF);
    regWrite(4'd1, 32'h80);
    regRead(4'd1, v); chk("R2 locked while running", v, 32'h0);
    periphReq = 4'b0100;
    waitIdle();
    chk("R9 released w0", mem[128], mem[64]);
    chk("R9 released w1", mem[129], mem[65]);
    regRead(4'd0, v); chk("R9 level shown", v, 32'h0E);
    periphReq = '0;
    regWrite(4'd0, 32'h6);

    // R9 + R10: destination pacing stalls, then abort
    fillData();
    putCb(0, mkTi(1, 1, 0, 0, 1) | (32'h1 << 6) | (32'd1 << 16), 32'h100, 32'h200, 8, 0);
    startAt(32'h0);
    idleFor(30);
    regRead(4'd0, v); chk("R9 dst stalled", v, 32'h21);
    regWrite(4'd0, 32'h4000_0000);
    idleFor(4);
    regRead(4'd0, v); chk("R10 aborted status", v, 32'h0);
    chk("R10 no write", mem[128], 32'hDEAD_BEEF);
    chk("R10 irq", 32'(irq), 0);

    // R11: source read error
    fillData();
    putCb(0, mkTi(1, 1, 0, 0, 1), 32'h100, 32'h200, 8, 0);
    errAddr = 32'h100;
    startAt(32'h0); waitIdle();
    errAddr = 32'hFFFF_FFFF;
    regRead(4'd0, v); chk("R11 status", v, 32'h100);
    regRead(4'd8, v); chk("R11 errreg", v, 32'h1);
    chk("R11 no write", mem[128], 32'hDEAD_BEEF);
    regWrite(4'd8, 32'h7);
    regRead(4'd8, v); chk("R11 errreg cleared", v, 0);
    regRead(4'd0, v); chk("R11 status cleared", v, 0);

    // R12: self-clearing channel reset during a stall
    fillData();
    putCb(0, mkTi(1, 1, 0, 0, 1) | (32'h1 << 10) | (32'd2 << 16), 32'h100, 32'h200, 8, 0);
    startAt(32'h0);
    idleFor(10);
    regWrite(4'd0, 32'h8000_0000);
    regRead(4'd0, v); chk("R12 busy", v, 32'h8000_0000);
    idleFor(RC + 2);
    regRead(4'd0, v); chk("R12 cleared", v, 0);
    regRead(4'd2, v); chk("R12 ctrl cleared", v, 0);
    regRead(4'd1, v); chk("R12 cbaddr cleared", v, 0);
    chk("R12 memReq", 32'(memReq), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule